// File: doc/BRIEF.md
# DMA Snoop and Load-Locked Reservation Monitor

This block sits next to a processor's internal data cache and watches transfers that I/O-bus masters make into memory. It holds the processor's load-locked reservation. The reservation is a lock flag plus the 32-byte block that the last load-locked touched. The block decides which incoming transfers destroy that reservation and reports the result of each store-conditional.

The block also keeps a shadow directory of the data-cache lines the processor has filled: a valid bit and a tag for each line, direct-mapped. When a DMA transfer hits a valid shadow line, the block issues a one-cycle invalidate request that carries the line's index and tag, and it marks the shadow entry invalid. A secondary-cache allocate permit follows processor line fills only. DMA traffic never produces it.

Every output is registered and appears one clock after the request that caused it. Reset is synchronous and active low.

Top module: `snoop_monitor`

## Requirements
- R1: A DMA transfer with `dma_excl` high clears the lock flag on the next clock, whatever its address and direction.
- R2: A non-exclusive DMA write clears the lock flag only when address bits [AW-1:5] equal the locked block. A write outside the block leaves the flag set.
- R3: Every block compare ignores address bits [4:0], so any byte inside the locked 32-byte block matches.
- R4: A non-exclusive DMA read never changes the lock flag.
- R5: A load-locked sets the lock flag on the next clock and records address bits [AW-1:5], replacing any earlier block. If a clearing event arrives in the same cycle as the load-locked, the load-locked wins.
- R6: A store-conditional raises `sc_done` for exactly one cycle, one clock later. `sc_ok` is high only if the flag was set and the block matched. The flag is clear after every store-conditional, whether it passed or failed.
- R7: A store-conditional fails when a clearing DMA transfer arrives in the same cycle.
- R8: A DMA transfer, read or write, that hits a valid shadow line gives `inv_vld` high for one cycle, one clock later. It carries `inv_idx` = address bits [IW+4:5] and `inv_tag` = address bits [AW-1:IW+5], with IW = log2(LINES) and a default of 4. The shadow line is then invalid.
- R9: A DMA transfer that maps to an invalid shadow line, or whose tag differs from the stored one, gives no invalidate.
- R10: `l2_alloc` pulses one clock after a processor fill (`fill_vld`) and never as a result of DMA traffic.
- R11: Reset clears the lock flag, the locked block, every shadow valid bit and all output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ll_vld | input | 1 | Load-locked request |
| ll_addr | input | AW | Load-locked address |
| sc_vld | input | 1 | Store-conditional request |
| sc_addr | input | AW | Store-conditional address |
| dma_vld | input | 1 | DMA transfer valid |
| dma_write | input | 1 | DMA direction, 1 = write |
| dma_excl | input | 1 | DMA transfer is exclusive |
| dma_addr | input | AW | DMA address |
| fill_vld | input | 1 | Processor filled an internal data-cache line |
| fill_addr | input | AW | Address of the filled line |
| lock_flag | output | 1 | Reservation held |
| sc_done | output | 1 | Store-conditional result valid |
| sc_ok | output | 1 | Store-conditional succeeded |
| inv_vld | output | 1 | Invalidate strobe for the data cache |
| inv_idx | output | IW | Index of the line to invalidate |
| inv_tag | output | AW-5-IW | Tag of the line to invalidate |
| l2_alloc | output | 1 | Secondary-cache allocate permit |

## Verification
The bench sends an exclusive read to an unrelated address. A design that gated exclusive kills by address would keep the reservation. It sends writes just inside and just outside the locked block, with differing low bits. A design that compared the full address, or that ignored the address, would pass the wrong store-conditional. It puts a DMA write and a store-conditional in the same cycle. A design with the wrong priority would report success there. On the directory side, it sends DMA to a line that was never filled, to an already invalidated line and to an aliasing tag, and a sloppy tag compare would fire a spurious invalidate for each of these.

// File: rtl/snoop_pkg.sv
// Shared constants and helpers for the DMA snoop monitor.
// Assumes a fixed 32-byte reservation and cache-line granule.
package snoop_pkg;
    localparam int unsigned GRAIN_BITS = 5;

    // Coarse address width that remains once the in-block offset is dropped.
    function automatic int unsigned blk_width(input int unsigned aw);
        return aw - GRAIN_BITS;
    endfunction
endpackage

// File: rtl/snoop_resv.sv
// Load-locked reservation keeper.
// Holds the lock flag and the locked 32-byte block. Judges store-conditionals
// and applies DMA kills. Assumes at most one load-locked and one
// store-conditional per cycle.
module snoop_resv
    import snoop_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ll_vld,
    input  logic [AW-1:0] ll_addr,
    input  logic          sc_vld,
    input  logic [AW-1:0] sc_addr,
    input  logic          dma_vld,
    input  logic          dma_write,
    input  logic          dma_excl,
    input  logic [AW-1:0] dma_addr,
    output logic          lock_flag,
    output logic          sc_done,
    output logic          sc_ok
);
    localparam int unsigned BW = blk_width(AW);

    logic [BW-1:0] lock_blk;
    logic          dma_kill;
    logic          sc_pass;

    // Decide whether this cycle's DMA transfer destroys the reservation.
    always_comb begin
        dma_kill = 1'b0;
        if (dma_vld) begin
            if (dma_excl)
                dma_kill = 1'b1;
            else if (dma_write && (dma_addr[AW-1:GRAIN_BITS] == lock_blk))
                dma_kill = 1'b1;
        end
    end

    // Store-conditional outcome: the flag is held, the block matches and no kill lands this cycle.
    always_comb begin
        sc_pass = sc_vld && lock_flag && !dma_kill &&
                  (sc_addr[AW-1:GRAIN_BITS] == lock_blk);
    end

    // Lock flag and locked block; a load-locked overrides any clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_flag <= 1'b0;
            lock_blk  <= '0;
        end else if (ll_vld) begin
            lock_flag <= 1'b1;
            lock_blk  <= ll_addr[AW-1:GRAIN_BITS];
        end else if (dma_kill || sc_vld) begin
            lock_flag <= 1'b0;
        end
    end

    // Registered store-conditional result pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_done <= 1'b0;
            sc_ok   <= 1'b0;
        end else begin
            sc_done <= sc_vld;
            sc_ok   <= sc_pass;
        end
    end
endmodule

// File: rtl/snoop_dir.sv
// Shadow tag directory for the internal data cache.
// Direct-mapped with 32-byte lines. Processor fills mark a line valid. A DMA
// hit clears the line and issues a one-cycle invalidate request. Assumes the
// cache reports every fill it makes.
module snoop_dir
    import snoop_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned LINES = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fill_vld,
    input  logic [AW-1:0]                 fill_addr,
    input  logic                          dma_vld,
    input  logic [AW-1:0]                 dma_addr,
    output logic                          inv_vld,
    output logic [$clog2(LINES)-1:0]      inv_idx,
    output logic [AW-GRAIN_BITS-$clog2(LINES)-1:0] inv_tag
);
    localparam int unsigned IW = $clog2(LINES);
    localparam int unsigned TW = AW - GRAIN_BITS - IW;
    localparam int unsigned TL = GRAIN_BITS + IW;

    logic [LINES-1:0] line_vld;
    logic [TW-1:0]    line_tag [LINES];
    logic [IW-1:0]    d_idx, f_idx;
    logic [TW-1:0]    d_tag, f_tag;
    logic             d_hit;

    // Split the DMA and fill addresses into index and tag.
    always_comb begin
        d_idx = dma_addr[TL-1:GRAIN_BITS];
        d_tag = dma_addr[AW-1:TL];
        f_idx = fill_addr[TL-1:GRAIN_BITS];
        f_tag = fill_addr[AW-1:TL];
    end

    // DMA hit: the indexed line is valid and its tag matches.
    always_comb begin
        d_hit = dma_vld && line_vld[d_idx] && (line_tag[d_idx] == d_tag);
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Per-line valid bit and tag; a fill overrides a same-cycle snoop clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_vld[g] <= 1'b0;
                line_tag[g] <= '0;
            end else if (fill_vld && (f_idx == IW'(g))) begin
                line_vld[g] <= 1'b1;
                line_tag[g] <= f_tag;
            end else if (d_hit && (d_idx == IW'(g))) begin
                line_vld[g] <= 1'b0;
            end
        end
    end

    // Registered invalidate request toward the data cache.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_vld <= 1'b0;
            inv_idx <= '0;
            inv_tag <= '0;
        end else begin
            inv_vld <= d_hit;
            if (d_hit) begin
                inv_idx <= d_idx;
                inv_tag <= d_tag;
            end
        end
    end
endmodule

// File: rtl/snoop_monitor.sv
// Top level of the DMA snoop and reservation monitor.
// Joins the reservation keeper and the shadow directory. Only processor fills
// grant secondary-cache allocation; DMA never does.
module snoop_monitor
    import snoop_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned LINES = 16
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    ll_vld,
    input  logic [AW-1:0]                           ll_addr,
    input  logic                                    sc_vld,
    input  logic [AW-1:0]                           sc_addr,
    input  logic                                    dma_vld,
    input  logic                                    dma_write,
    input  logic                                    dma_excl,
    input  logic [AW-1:0]                           dma_addr,
    input  logic                                    fill_vld,
    input  logic [AW-1:0]                           fill_addr,
    output logic                                    lock_flag,
    output logic                                    sc_done,
    output logic                                    sc_ok,
    output logic                                    inv_vld,
    output logic [$clog2(LINES)-1:0]                inv_idx,
    output logic [AW-GRAIN_BITS-$clog2(LINES)-1:0]  inv_tag,
    output logic                                    l2_alloc
);
    snoop_resv #(.AW(AW)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .ll_vld    (ll_vld),
        .ll_addr   (ll_addr),
        .sc_vld    (sc_vld),
        .sc_addr   (sc_addr),
        .dma_vld   (dma_vld),
        .dma_write (dma_write),
        .dma_excl  (dma_excl),
        .dma_addr  (dma_addr),
        .lock_flag (lock_flag),
        .sc_done   (sc_done),
        .sc_ok     (sc_ok)
    );

    snoop_dir #(.AW(AW), .LINES(LINES)) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_vld  (fill_vld),
        .fill_addr (fill_addr),
        .dma_vld   (dma_vld),
        .dma_addr  (dma_addr),
        .inv_vld   (inv_vld),
        .inv_idx   (inv_idx),
        .inv_tag   (inv_tag)
    );

    // Secondary-cache allocate permit follows processor fills only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            l2_alloc <= 1'b0;
        else
            l2_alloc <= fill_vld;
    end
endmodule

// File: rtl/snoop_monitor_chk.sv
// Property checker for snoop_monitor, attached with bind.
// Observes the top-level ports only.
module snoop_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic ll_vld,
    input logic sc_vld,
    input logic dma_vld,
    input logic dma_write,
    input logic dma_excl,
    input logic fill_vld,
    input logic lock_flag,
    input logic sc_done,
    input logic sc_ok,
    input logic l2_alloc
);
    AST_EXCL_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_vld && dma_excl && !ll_vld) |=> !lock_flag);  // R1
    AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_flag && dma_vld && !dma_write && !dma_excl && !sc_vld && !ll_vld) |=> lock_flag);  // R4
    AST_LL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ll_vld |=> lock_flag);  // R5
    AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_vld && !ll_vld) |=> (sc_done && !lock_flag));  // R6
    AST_SC_NOLOCK_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_vld && !lock_flag) |=> !sc_ok);  // R6
    AST_SC_KILLED_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_vld && dma_vld && dma_excl) |=> !sc_ok);  // R7
    AST_L2_CPU_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        l2_alloc |-> $past(fill_vld));  // R10

    // Result flag only with its valid strobe.
    always_comb begin
        if (rst_n && sc_ok)
            AST_OK_WITH_DONE: assert (sc_done);  // R6
    end
endmodule

bind snoop_monitor snoop_monitor_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ll_vld    (ll_vld),
    .sc_vld    (sc_vld),
    .dma_vld   (dma_vld),
    .dma_write (dma_write),
    .dma_excl  (dma_excl),
    .fill_vld  (fill_vld),
    .lock_flag (lock_flag),
    .sc_done   (sc_done),
    .sc_ok     (sc_ok),
    .l2_alloc  (l2_alloc)
);

// File: tb/snoop_monitor_test.sv
// Directed bench for snoop_monitor: one task per scenario.
module snoop_monitor_test;
    localparam int AW = 32;
    localparam int LINES = 16;
    localparam int IW = 4;
    localparam int TW = AW - 5 - IW;

    logic clk = 1'b0;
    logic rst_n;
    logic ll_vld, sc_vld, dma_vld, dma_write, dma_excl, fill_vld;
    logic [AW-1:0] ll_addr, sc_addr, dma_addr, fill_addr;
    logic lock_flag, sc_done, sc_ok, inv_vld, l2_alloc;
    logic [IW-1:0] inv_idx;
    logic [TW-1:0] inv_tag;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    snoop_monitor #(.AW(AW), .LINES(LINES)) uut (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle();
        ll_vld = 0; sc_vld = 0; dma_vld = 0; dma_write = 0; dma_excl = 0; fill_vld = 0;
        ll_addr = '0; sc_addr = '0; dma_addr = '0; fill_addr = '0;
    endtask

    // Inputs are already driven after a negedge; cross one posedge and come back to idle.
    task automatic step();
        @(negedge clk);
        idle();
    endtask

    task automatic do_ll(input logic [AW-1:0] a);
        ll_vld = 1; ll_addr = a; step();
    endtask

    task automatic do_dma(input logic [AW-1:0] a, input bit wr, input bit ex);
        dma_vld = 1; dma_addr = a; dma_write = wr; dma_excl = ex; step();
    endtask

    task automatic do_sc(input logic [AW-1:0] a, input bit exp_ok, input string req);
        sc_vld = 1; sc_addr = a; step();
        chk(sc_done == 1'b1, req, sc_done, 1);
        chk(sc_ok == exp_ok, req, sc_ok, exp_ok);
        chk(lock_flag == 1'b0, req, lock_flag, 0);
    endtask

    task automatic t_reset();
        rst_n = 0; idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk(lock_flag == 0 && sc_done == 0 && inv_vld == 0 && l2_alloc == 0, "R11 reset", lock_flag, 0);
        do_sc(32'h0, 1'b0, "R11 reset clears lock");
    endtask

    task automatic t_ll_sc();
        do_ll(32'h0000_1000);
        chk(lock_flag == 1, "R5 ll sets", lock_flag, 1);
        do_sc(32'h0000_101F, 1'b1, "R3 same block other byte");
        do_ll(32'h0000_1000);
        do_sc(32'h0000_1020, 1'b0, "R6 next block fails");
        do_sc(32'h0000_1000, 1'b0, "R6 flag cleared by prior sc");
    endtask

    task automatic t_replace();
        do_ll(32'h0000_2000);
        do_ll(32'h0000_3000);
        do_sc(32'h0000_2000, 1'b0, "R5 old block replaced");
        do_ll(32'h0000_2000);
        do_ll(32'h0000_3000);
        do_sc(32'h0000_3004, 1'b1, "R5 new block holds");
    endtask

    task automatic t_excl();
        do_ll(32'h0000_4000);
        do_dma(32'hABCD_0000, 1'b0, 1'b1);
        chk(lock_flag == 0, "R1 exclusive read elsewhere kills", lock_flag, 0);
        do_ll(32'h0000_4000);
        // load-locked wins over a same-cycle exclusive kill
        ll_vld = 1; ll_addr = 32'h0000_4000; dma_vld = 1; dma_excl = 1; dma_addr = 32'h0000_4000; step();
        chk(lock_flag == 1, "R5 ll beats kill", lock_flag, 1);
    endtask

    task automatic t_write();
        do_ll(32'h0000_5000);
        do_dma(32'h0000_5020, 1'b1, 1'b0);
        chk(lock_flag == 1, "R2 write outside keeps", lock_flag, 1);
        do_dma(32'h0000_4FFF, 1'b1, 1'b0);
        chk(lock_flag == 1, "R2 write below keeps", lock_flag, 1);
        do_dma(32'h0000_501C, 1'b0, 1'b0);
        chk(lock_flag == 1, "R4 read inside keeps", lock_flag, 1);
        do_dma(32'h0000_501C, 1'b1, 1'b0);
        chk(lock_flag == 0, "R2 R3 write inside kills", lock_flag, 0);
    endtask

    task automatic t_race();
        do_ll(32'h0000_6000);
        sc_vld = 1; sc_addr = 32'h0000_6000;
        dma_vld = 1; dma_write = 1; dma_addr = 32'h0000_6010; step();
        chk(sc_done == 1 && sc_ok == 0, "R7 dma beats sc", sc_ok, 0);
        do_ll(32'h0000_6000);
        sc_vld = 1; sc_addr = 32'h0000_6000;
        dma_vld = 1; dma_write = 1; dma_addr = 32'h0000_7000; step();
        chk(sc_ok == 1, "R7 unrelated write no race", sc_ok, 1);
    endtask

    task automatic t_snoop();
        logic [AW-1:0] x;
        x = 32'h0001_2340;
        do_dma(x, 1'b1, 1'b0);
        chk(inv_vld == 0, "R9 never filled", inv_vld, 0);
        fill_vld = 1; fill_addr = x; step();
        chk(l2_alloc == 1, "R10 fill permits l2", l2_alloc, 1);
        do_dma(x ^ 32'h0000_0200, 1'b0, 1'b0);
        chk(inv_vld == 0, "R9 alias tag", inv_vld, 0);
        chk(l2_alloc == 0, "R10 dma no l2", l2_alloc, 0);
        do_dma(x | 32'h1F, 1'b0, 1'b0);
        chk(inv_vld == 1, "R8 hit strobe", inv_vld, 1);
        chk(inv_idx == x[8:5], "R8 index", inv_idx, x[8:5]);
        chk(inv_tag == x[31:9], "R8 tag", inv_tag, x[31:9]);
        chk(l2_alloc == 0, "R10 dma no l2", l2_alloc, 0);
        step();
        chk(inv_vld == 0, "R8 single cycle", inv_vld, 0);
        do_dma(x, 1'b1, 1'b0);
        chk(inv_vld == 0, "R8 line now invalid", inv_vld, 0);
    endtask

    initial begin
        idle();
        rst_n = 0;
        @(negedge clk);
        t_reset();
        t_ll_sc();
        t_replace();
        t_excl();
        t_write();
        t_race();
        t_snoop();
        do_ll(32'h0000_8000);
        rst_n = 0; step(); rst_n = 1;
        chk(lock_flag == 0, "R11 mid-run reset", lock_flag, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #100000;
        fails++; checks++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule